// File: doc/BRIEF.md
# BAR Size Discovery Engine

This host-side sequencer measures the address window that one base address register (BAR) of a device decodes. A one-cycle start pulse names the slot. The engine drives a plain configuration read/write port with a request/acknowledge handshake. It first keeps the slot's current contents. It then writes all ones, reads the result back and turns the writable-bit mask into a byte count. Last, it puts the original contents back. The result and a 64-bit flag come out together with a one-cycle done pulse.

A memory BAR whose type field marks it as 64-bit borrows the next slot as its upper half. In that case the engine probes both slots and computes the size over the joined 64-bit mask. A slot whose writable bits all read back as zero is reported as unimplemented with a size of zero. Address assignment is not part of this block; it is left to the enumeration software that uses it.

Top module: `bar_size_probe`

## Requirements
- R1: After reset, cfg_req_o, done_o and is64_o are 0 and size_o is 0.
- R2: A start pulse seen while idle latches bar_idx_i. The first access is then a read (cfg_we_o=0) of that slot, whose data is kept as the saved value.
- R3: The second access writes 0xFFFFFFFF to the same slot. The third access reads the same slot back.
- R4: For a 32-bit BAR, size_o = (bitwise NOT of the readback with bits 3:0 forced to 0) + 1, zero-extended to 64 bits. For example, a readback of 0xFFFF000F gives 0x10000 and 0xFFFFF000 gives 0x1000. Every reported size is zero or a power of two.
- R5: When readback bits 2:1 equal 2'b10 and the slot is not the last one, the BAR is 64-bit. Slot+1 is then read, written with 0xFFFFFFFF and read back, in that order. size_o = NOT{upper readback, lower readback with bits 3:0 cleared} + 1, and is64_o = 1.
- R6: When bits 2:1 equal 2'b10 on the last slot (NUM_BARS-1), the BAR is handled as 32-bit. No other slot is accessed and is64_o = 0.
- R7: When the masked readback is zero (the lower half alone for 32-bit, the joined 64 bits for a 64-bit BAR), size_o is 0.
- R8: After the readbacks the engine writes the saved values back, the lower slot first and then the upper slot. This gives 4 accesses in all for a 32-bit BAR and 8 for a 64-bit BAR, and every slot ends with its original contents.
- R9: cfg_req_o stays high with stable cfg_we_o, cfg_addr_o and cfg_wdata_o until cfg_ack_i. The next step starts only after the acknowledge.
- R10: done_o is high for exactly one cycle: the cycle after the acknowledge of the final restore write. size_o and is64_o are valid in that cycle and hold until the next done, and cfg_req_o is low.
- R11: A start pulse while a discovery is in progress is ignored. The access sequence and the result of the running discovery are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| bar_idx_i | input | AW | BAR slot to probe; must be below NUM_BARS |
| cfg_req_o | output | 1 | Configuration access request |
| cfg_we_o | output | 1 | 1 = write, 0 = read |
| cfg_addr_o | output | AW | Slot index of the access |
| cfg_wdata_o | output | DW | Write data |
| cfg_ack_i | input | 1 | Access acknowledge; read data valid with it |
| cfg_rdata_i | input | DW | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| size_o | output | 2*DW | Window size in bytes, 0 if unimplemented |
| is64_o | output | 1 | BAR was probed as a 64-bit pair |

## Verification
The result is due in one cycle only: done_o rises in the cycle right after the acknowledge of the last restore write. size_o and is64_o must be valid in that same cycle. The bench's slot model answers each request after a random 0 to 3 cycle wait and records the cycle count of every acknowledge it gives. It samples all outputs on falling edges, checks that done appears exactly one cycle after the last recorded acknowledge and is gone one cycle later, and reads size_o and is64_o in the done cycle. Because the acknowledge wait is random, every handshake step is stretched by varying amounts. This shows that the sequence advances on acknowledges rather than on a fixed count.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SAVE_LO,
    ST_ONES_LO,
    ST_BACK_LO,
    ST_SAVE_HI,
    ST_ONES_HI,
    ST_BACK_HI,
    ST_REST_LO,
    ST_REST_HI
  } step_e;

  // memory BAR type field position and the 64-bit code
  localparam int unsigned TYPE_LSB = 1;
  localparam logic [1:0]  TYPE_64  = 2'b10;
endpackage

// File: rtl/bsp_seq.sv
module bsp_seq
  import bsp_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter int DW       = 32,
  parameter int AW       = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] idx_i,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] lo_rb_o,
  output logic [DW-1:0] hi_rb_o,
  output logic          pair_o,
  output logic          finish_o
);
  localparam logic [AW-1:0] LAST = AW'(NUM_BARS - 1);
  localparam logic [DW-1:0] ONES = '1;

  step_e         step_q;
  logic [AW-1:0] idx_q;
  logic          pair_q;
  logic [DW-1:0] save_lo_q, save_hi_q, rb_lo_q, rb_hi_q;
  logic          hit, pair_det;

  assign hit      = req_o & ack_i;
  assign pair_det = (rdata_i[TYPE_LSB +: 2] == TYPE_64) && (idx_q != LAST);

  always_comb begin
    req_o   = (step_q != ST_IDLE);
    we_o    = 1'b0;
    addr_o  = idx_q;
    wdata_o = '0;
    unique case (step_q)
      ST_ONES_LO: begin we_o = 1'b1; wdata_o = ONES; end
      ST_SAVE_HI,
      ST_BACK_HI: addr_o = idx_q + AW'(1);
      ST_ONES_HI: begin we_o = 1'b1; addr_o = idx_q + AW'(1); wdata_o = ONES; end
      ST_REST_LO: begin we_o = 1'b1; wdata_o = save_lo_q; end
      ST_REST_HI: begin we_o = 1'b1; addr_o = idx_q + AW'(1); wdata_o = save_hi_q; end
      default: ;
    endcase
  end

  assign finish_o = hit && ((step_q == ST_REST_HI) || (step_q == ST_REST_LO && !pair_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q    <= ST_IDLE;
      idx_q     <= '0;
      pair_q    <= 1'b0;
      save_lo_q <= '0;
      save_hi_q <= '0;
      rb_lo_q   <= '0;
      rb_hi_q   <= '0;
    end else begin
      unique case (step_q)
        ST_IDLE: if (start_i) begin
          idx_q  <= idx_i;
          step_q <= ST_SAVE_LO;
        end
        ST_SAVE_LO: if (hit) begin save_lo_q <= rdata_i; step_q <= ST_ONES_LO; end
        ST_ONES_LO: if (hit) step_q <= ST_BACK_LO;
        ST_BACK_LO: if (hit) begin
          rb_lo_q <= rdata_i;
          pair_q  <= pair_det;
          step_q  <= pair_det ? ST_SAVE_HI : ST_REST_LO;
        end
        ST_SAVE_HI: if (hit) begin save_hi_q <= rdata_i; step_q <= ST_ONES_HI; end
        ST_ONES_HI: if (hit) step_q <= ST_BACK_HI;
        ST_BACK_HI: if (hit) begin rb_hi_q <= rdata_i; step_q <= ST_REST_LO; end
        ST_REST_LO: if (hit) step_q <= pair_q ? ST_REST_HI : ST_IDLE;
        ST_REST_HI: if (hit) step_q <= ST_IDLE;
        default: step_q <= ST_IDLE;
      endcase
    end
  end

  assign lo_rb_o = rb_lo_q;
  assign hi_rb_o = rb_hi_q;
  assign pair_o  = pair_q;

  // request must not change until it is acknowledged
  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o));

  // a running discovery keeps its slot
  p_idx_kept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && $past(req_o) |-> $stable(idx_q));
endmodule

// File: rtl/bsp_size_calc.sv
module bsp_size_calc #(
  parameter int DW     = 32,
  parameter int LOW_RO = 4
) (
  input  logic [DW-1:0]   lo_rb_i,
  input  logic [DW-1:0]   hi_rb_i,
  input  logic            pair_i,
  output logic [2*DW-1:0] size_o
);
  localparam logic [DW-1:0] LOW_MASK = DW'((1 << LOW_RO) - 1);

  logic [DW-1:0]   lo_m, hi_eff;
  logic [2*DW-1:0] mask;
  logic            impl;

  always_comb begin
    lo_m   = lo_rb_i & ~LOW_MASK;
    hi_eff = pair_i ? hi_rb_i : '1;
    mask   = {hi_eff, lo_m};
    impl   = pair_i ? (mask != '0) : (lo_m != '0);
    size_o = impl ? (~mask + (2*DW)'(1)) : '0;
  end
endmodule

// File: rtl/bar_size_probe.sv
module bar_size_probe #(
  parameter  int NUM_BARS = 6,
  parameter  int DW       = 32,
  parameter  int LOW_RO   = 4,
  localparam int AW       = $clog2(NUM_BARS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   bar_idx_i,
  output logic            cfg_req_o,
  output logic            cfg_we_o,
  output logic [AW-1:0]   cfg_addr_o,
  output logic [DW-1:0]   cfg_wdata_o,
  input  logic            cfg_ack_i,
  input  logic [DW-1:0]   cfg_rdata_i,
  output logic            done_o,
  output logic [2*DW-1:0] size_o,
  output logic            is64_o
);
  logic [DW-1:0]   lo_rb, hi_rb;
  logic            pair, finish;
  logic [2*DW-1:0] size_calc;

  bsp_seq #(.NUM_BARS(NUM_BARS), .DW(DW), .AW(AW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .idx_i    (bar_idx_i),
    .ack_i    (cfg_ack_i),
    .rdata_i  (cfg_rdata_i),
    .req_o    (cfg_req_o),
    .we_o     (cfg_we_o),
    .addr_o   (cfg_addr_o),
    .wdata_o  (cfg_wdata_o),
    .lo_rb_o  (lo_rb),
    .hi_rb_o  (hi_rb),
    .pair_o   (pair),
    .finish_o (finish)
  );

  bsp_size_calc #(.DW(DW), .LOW_RO(LOW_RO)) u_calc (
    .lo_rb_i (lo_rb),
    .hi_rb_i (hi_rb),
    .pair_i  (pair),
    .size_o  (size_calc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      size_o <= '0;
      is64_o <= 1'b0;
    end else begin
      done_o <= finish;
      if (finish) begin
        size_o <= size_calc;
        is64_o <= pair;
      end
    end
  end

  p_done_after_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cfg_req_o && cfg_ack_i));

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cfg_req_o);

  p_size_pow2_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones(size_o) <= 1);

  p_pair_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && is64_o |-> $past(cfg_addr_o) != '0);
endmodule

// File: tb/tb_bar_size_probe.sv
module tb_bar_size_probe;
  localparam int NB = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  bar_idx = '0;
  logic        req, we, ack = 1'b0, done, is64;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata = '0;
  logic [63:0] size;

  always #2.5 clk = ~clk;

  bar_size_probe dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bar_idx_i(bar_idx),
    .cfg_req_o(req), .cfg_we_o(we), .cfg_addr_o(addr), .cfg_wdata_o(wdata),
    .cfg_ack_i(ack), .cfg_rdata_i(rdata),
    .done_o(done), .size_o(size), .is64_o(is64)
  );

  int total = 0, bad = 0, cyc = 0, last_ack_cyc = 0, n_acc = 0, lat = 0;
  logic [31:0] regv [NB], wmask [NB], romask [NB];
  logic        l_we [16];
  int          l_addr [16];
  logic [31:0] l_wd [16];

  always @(posedge clk) cyc <= cyc + 1;

  // slot model, acts on falling edges
  always @(negedge clk) begin
    if (ack) ack = 1'b0;
    else if (req) begin
      if (lat == 0) begin
        if (n_acc < 16) begin
          l_we[n_acc] = we; l_addr[n_acc] = int'(addr); l_wd[n_acc] = wdata;
        end
        n_acc++;
        if (int'(addr) < NB) begin
          if (we) regv[addr] = (wdata & wmask[addr]) | romask[addr];
          else    rdata = regv[addr];
        end else rdata = '0;
        ack = 1'b1;
        last_ack_cyc = cyc;
        lat = $urandom % 4;
      end else lat--;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // kind 0 unimplemented, 1 32-bit, 2 64-bit pair, 3 64-bit type at a lone slot
  task automatic set_slot(input int s, input int kind, input int k, input logic [3:0] ro);
    logic [63:0] m;
    m = ~((64'd1 << k) - 64'd1);
    case (kind)
      0: begin wmask[s] = '0; romask[s] = '0; end
      1, 3: begin wmask[s] = m[31:0]; romask[s] = {28'd0, ro}; end
      default: begin
        wmask[s] = m[31:0]; romask[s] = {28'd0, ro};
        wmask[s+1] = m[63:32]; romask[s+1] = '0;
        regv[s+1] = $urandom & wmask[s+1];
      end
    endcase
    regv[s] = ($urandom & wmask[s]) | romask[s];
  endtask

  task automatic fill_random();
    for (int s = 0; s < NB; s++) begin
      wmask[s] = 32'hFFFF_FFF0; romask[s] = '0; regv[s] = $urandom & 32'hFFFF_FFF0;
    end
  endtask

  task automatic probe(input int idx, input longint unsigned exp_sz, input bit exp64,
                       input bit kick, input string rq);
    logic [31:0] orig [NB];
    int t, en;
    bit ok;
    for (int s = 0; s < NB; s++) orig[s] = regv[s];
    n_acc = 0;
    @(negedge clk); start = 1'b1; bar_idx = 3'(idx);
    @(negedge clk); start = 1'b0;
    if (kick) begin
      repeat (3) @(negedge clk);
      start = 1'b1; bar_idx = 3'((idx + 2) % NB);
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    do begin @(negedge clk); t++; end while (!done && t < 400);
    chk(done == 1'b1, "R10", {rq, " done seen"}, done, 1);
    chk(cyc == last_ack_cyc + 1, "R10", {rq, " done timing"}, cyc, last_ack_cyc + 1);
    chk(!req, "R10", {rq, " idle at done"}, req, 0);
    chk(size == exp_sz, rq, "size", size, exp_sz);
    chk(is64 == exp64, rq, "is64", is64, exp64);
    en = exp64 ? 8 : 4;
    chk(n_acc == en, "R8", {rq, " access count"}, n_acc, en);
    if (n_acc == en) begin
      ok = !l_we[0] && l_addr[0] == idx && l_we[1] && l_addr[1] == idx &&
           l_wd[1] == 32'hFFFF_FFFF && !l_we[2] && l_addr[2] == idx;
      chk(ok, "R2 R3", {rq, " probe order"}, {l_we[1], l_addr[1][3:0]}, {1'b1, 4'(idx)});
      if (exp64) begin
        ok = !l_we[3] && l_addr[3] == idx + 1 && l_we[4] && l_addr[4] == idx + 1 &&
             l_wd[4] == 32'hFFFF_FFFF && !l_we[5] && l_addr[5] == idx + 1;
        chk(ok, "R5", {rq, " upper order"}, l_addr[4], idx + 1);
        ok = l_we[6] && l_addr[6] == idx && l_wd[6] == orig[idx] &&
             l_we[7] && l_addr[7] == idx + 1 && l_wd[7] == orig[idx+1];
        chk(ok, "R8", {rq, " restore order"}, l_wd[7], orig[idx+1]);
      end else begin
        ok = l_we[3] && l_addr[3] == idx && l_wd[3] == orig[idx];
        chk(ok, "R8", {rq, " restore"}, l_wd[3], orig[idx]);
      end
    end
    ok = 1'b1;
    for (int s = 0; s < NB; s++) if (regv[s] !== orig[s]) ok = 1'b0;
    chk(ok, "R8", {rq, " contents restored"}, ok, 1);
    @(negedge clk);
    chk(!done, "R10", {rq, " done one cycle"}, done, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    fill_random();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req && !done && !is64 && size == 0, "R1", "reset state",
        {req, done, is64}, 0);

    // directed corners
    fill_random(); set_slot(1, 1, 16, 4'hF);
    probe(1, 64'h1_0000, 0, 0, "R4 ffff000f");
    fill_random(); set_slot(0, 1, 12, 4'h0);
    probe(0, 64'h1000, 0, 0, "R4 fffff000");
    fill_random(); set_slot(2, 1, 31, 4'h8);
    probe(2, 64'h8000_0000, 0, 0, "R4 top bit");
    fill_random(); set_slot(3, 0, 4, 4'h0);
    probe(3, 0, 0, 0, "R7 unimplemented");
    fill_random(); set_slot(0, 2, 40, 4'h4);
    probe(0, 64'd1 << 40, 1, 0, "R5 pair 2^40");
    fill_random(); set_slot(4, 2, 63, 4'hC);
    probe(4, 64'd1 << 63, 1, 0, "R5 pair 2^63");
    fill_random(); set_slot(2, 2, 20, 4'h4);
    probe(2, 64'd1 << 20, 1, 0, "R5 pair low");
    fill_random(); set_slot(5, 3, 24, 4'h4);
    probe(5, 64'd1 << 24, 0, 0, "R6 last slot");
    fill_random(); set_slot(1, 2, 36, 4'h4);
    probe(1, 64'd1 << 36, 1, 1, "R11 kick pair");
    fill_random(); set_slot(3, 1, 8, 4'h0);
    probe(3, 64'h100, 0, 1, "R11 kick 32");

    // constrained random
    for (int i = 0; i < 40; i++) begin
      int kind, idx, k;
      fill_random();
      kind = $urandom % 3;
      idx  = (kind == 2) ? $urandom % (NB - 1) : $urandom % NB;
      k    = (kind == 2) ? 4 + $urandom % 60 : 4 + $urandom % 28;
      set_slot(idx, kind, k, (kind == 2) ? 4'h4 : {$urandom % 2 == 0, 3'b000});
      probe(idx, (kind == 0) ? 0 : (64'd1 << k), kind == 2, ($urandom % 4) == 0,
            (kind == 0) ? "R7 rnd" : (kind == 2) ? "R5 rnd" : "R4 rnd");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule